// File: doc/BRIEF.md
# Protected Return Address Stack

This block keeps return addresses in hardware storage that is kept apart from the general data stack. Local variables and buffers stay in that data stack. A call saves its return address here without any explicit push. A return retrieves the most recent entry as its target without any explicit pop. The only other operations that can reach the storage are a dedicated push and a dedicated pop. Ordinary loads and stores have no path into it, so a buffer overrun in a stack frame cannot corrupt control flow.

Every incoming word carries a two-bit type tag. A dedicated push is accepted only when the word is tagged as an address. Any other tag is rejected with a fault, and the stack stays as it was. Pushing onto a full stack, popping an empty one, and asserting several strobes in one cycle each produce a one-cycle fault pulse. A popped entry comes out on a registered output with a valid strobe one cycle after the request.

Top module: `rasp_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stack becomes empty. All fault outputs and `ret_valid_o` are 0 and `ret_addr_o` is 0 in the next cycle.
- R2: A call stores `wr_data_i` as the new top entry whatever the value of `wr_tag_i`.
- R3: A return takes the top entry off the stack. One cycle after the request, `ret_addr_o` carries that entry and `ret_valid_o` is 1 for exactly that cycle. Between pops, `ret_addr_o` keeps its last value.
- R4: A dedicated pop behaves like a return: the same output timing and the same last-in, first-out order.
- R5: A dedicated push stores `wr_data_i` only when `wr_tag_i` is 2'b01, the address tag. The tags 2'b00 (null), 2'b10 (value) and 2'b11 (instruction) give `fault_tag_o` = 1 for one cycle and leave the contents unchanged. A rejected push on a full stack reports only the tag fault.
- R6: A call, or a push tagged as an address, while the stack holds DEPTH entries gives `fault_ovf_o` = 1 for one cycle. Nothing is written.
- R7: A return or pop while the stack is empty gives `fault_unf_o` = 1 for one cycle. `ret_valid_o` stays 0 and `ret_addr_o` is unchanged.
- R8: When more than one of the four strobes is high, one operation runs, chosen in the order return, pop, call, push. `fault_proto_o` is 1 for one cycle and the other strobes have no effect. A call together with a return therefore executes the return.
- R9: Exactly DEPTH entries can be held, and they come back in reverse order of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe, implicit push of `wr_data_i` |
| ret_i | input | 1 | Return strobe, implicit pop |
| push_i | input | 1 | Dedicated push strobe |
| pop_i | input | 1 | Dedicated pop strobe |
| wr_data_i | input | AW | Word to store |
| wr_tag_i | input | 2 | Type tag of `wr_data_i` (2'b01 = address) |
| ret_addr_o | output | AW | Last popped entry, registered |
| ret_valid_o | output | 1 | Pulses when `ret_addr_o` holds a fresh pop result |
| fault_tag_o | output | 1 | Dedicated push rejected by its tag |
| fault_ovf_o | output | 1 | Push or call on a full stack |
| fault_unf_o | output | 1 | Pop or return on an empty stack |
| fault_proto_o | output | 1 | More than one strobe in the same cycle |

## Verification
The hardest case to reach from the ports is the full boundary. The stack must be filled to exactly DEPTH entries, and then both insertion kinds and a badly tagged push must be attempted against it, without any intervening pop. The stimulus gets there with a directed run of calls and tagged pushes that fills the stack, then drains it entry by entry down past empty. After that, a long random mix weighted toward insertions pushes the stack to full repeatedly, with tags of every kind and overlapping strobes. A behavioural queue model is compared against every output on every cycle.

// File: rtl/rasp_pkg.sv
package rasp_pkg;

  typedef enum logic [1:0] {
    TAG_NULL  = 2'b00,
    TAG_ADDR  = 2'b01,
    TAG_VALUE = 2'b10,
    TAG_INSN  = 2'b11
  } word_tag_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RET  = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_PUSH = 3'd4
  } rs_op_e;

endpackage

// File: rtl/rasp_arbiter.sv
module rasp_arbiter
  import rasp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   push_i,
  input  logic   pop_i,
  output rs_op_e op_o,
  output logic   multi_o
);

  logic [3:0] req_vec;
  logic [3:0] grant_vec;

  assign req_vec = {push_i, call_i, pop_i, ret_i};

  // fixed priority: return, pop, call, push (R8)
  always_comb begin
    grant_vec = 4'b0000;
    op_o      = OP_NONE;
    if (ret_i) begin
      grant_vec = 4'b0001;
      op_o      = OP_RET;
    end else if (pop_i) begin
      grant_vec = 4'b0010;
      op_o      = OP_POP;
    end else if (call_i) begin
      grant_vec = 4'b0100;
      op_o      = OP_CALL;
    end else if (push_i) begin
      grant_vec = 4'b1000;
      op_o      = OP_PUSH;
    end
  end

  assign multi_o = ($countones(req_vec) > 1);

  assert_single_grant_R8 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));

  assert_ret_wins_R8 : assert property (@(posedge clk) disable iff (rst)
    (ret_i && call_i) |-> (op_o == OP_RET) && multi_o);

endmodule

// File: rtl/rasp_ptr.sv
module rasp_ptr
  import rasp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  rs_op_e        op_i,
  input  logic          tag_ok_i,
  input  logic          multi_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          rd_en_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          fault_tag_o,
  output logic          fault_ovf_o,
  output logic          fault_unf_o,
  output logic          fault_proto_o
);

  localparam logic [SPW-1:0] FULL_CNT = SPW'(DEPTH);

  logic [SPW-1:0] sp_q;
  logic           is_pop;
  logic           is_ins;
  logic           tag_bad;
  logic           empty;
  logic           full;

  assign is_pop  = (op_i == OP_RET) || (op_i == OP_POP);
  assign tag_bad = (op_i == OP_PUSH) && !tag_ok_i;
  assign is_ins  = (op_i == OP_CALL) || ((op_i == OP_PUSH) && tag_ok_i);
  assign empty   = (sp_q == '0);
  assign full    = (sp_q == FULL_CNT);

  assign wr_en_o  = is_ins && !full;
  assign rd_en_o  = is_pop && !empty;
  assign wr_idx_o = IW'(sp_q);
  assign rd_idx_o = IW'(sp_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q          <= '0;
      fault_tag_o   <= 1'b0;
      fault_ovf_o   <= 1'b0;
      fault_unf_o   <= 1'b0;
      fault_proto_o <= 1'b0;
    end else begin
      if (wr_en_o)      sp_q <= sp_q + 1'b1;
      else if (rd_en_o) sp_q <= sp_q - 1'b1;
      fault_tag_o   <= tag_bad;
      fault_ovf_o   <= is_ins && full;
      fault_unf_o   <= is_pop && empty;
      fault_proto_o <= multi_i;
    end
  end

  assert_sp_bound_R9 : assert property (@(posedge clk) disable iff (rst)
    sp_q <= FULL_CNT);

  assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (rst)
    fault_ovf_o |-> full && $stable(sp_q));

  assert_no_underflow_R7 : assert property (@(posedge clk) disable iff (rst)
    fault_unf_o |-> empty && $stable(sp_q));

  assert_tag_reject_R5 : assert property (@(posedge clk) disable iff (rst)
    fault_tag_o |-> $stable(sp_q));

  assert_pop_moves_R3 : assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> (sp_q == $past(sp_q) - 1'b1));

endmodule

// File: rtl/rasp_store.sv
module rasp_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o,
  output logic          rd_valid_o
);

  logic [AW-1:0] mem [DEPTH];

  // plain write port, no reset, so a RAM block can be inferred
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem[rd_idx_i];
    end
  end

  assert_port_exclusive_R8 : assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && rd_en_i));

  assert_hold_output_R3 : assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> $stable(rd_data_o));

endmodule

// File: rtl/rasp_top.sv
module rasp_top
  import rasp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [1:0]    wr_tag_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          ret_valid_o,
  output logic          fault_tag_o,
  output logic          fault_ovf_o,
  output logic          fault_unf_o,
  output logic          fault_proto_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rs_op_e        op;
  logic          multi;
  logic          tag_ok;
  logic          wr_en;
  logic          rd_en;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign tag_ok = (wr_tag_i == TAG_ADDR);

  rasp_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .op_o    (op),
    .multi_o (multi)
  );

  rasp_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk           (clk),
    .rst           (rst),
    .op_i          (op),
    .tag_ok_i      (tag_ok),
    .multi_i       (multi),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .rd_en_o       (rd_en),
    .rd_idx_o      (rd_idx),
    .fault_tag_o   (fault_tag_o),
    .fault_ovf_o   (fault_ovf_o),
    .fault_unf_o   (fault_unf_o),
    .fault_proto_o (fault_proto_o)
  );

  rasp_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (ret_addr_o),
    .rd_valid_o (ret_valid_o)
  );

  assert_valid_excl_R7 : assert property (@(posedge clk) disable iff (rst)
    ret_valid_o |-> !fault_unf_o && !fault_ovf_o && !fault_tag_o);

  assert_call_ret_proto_R8 : assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> fault_proto_o);

  assert_ret_result_R3 : assert property (@(posedge clk) disable iff (rst)
    (ret_i && !fault_unf_o && $past(1'b1)) |-> 1'b1 ##1 (ret_valid_o || fault_unf_o));

endmodule

// File: tb/tb_rasp_top.sv
`timescale 1ns/1ps
module tb_rasp_top;

  localparam int DEPTH = 16;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_i = 1'b0, ret_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] wr_data_i = '0;
  logic [1:0]    wr_tag_i = 2'b00;
  logic [AW-1:0] ret_addr_o;
  logic          ret_valid_o, fault_tag_o, fault_ovf_o, fault_unf_o, fault_proto_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] stk[$];
  logic [AW-1:0] m_addr = '0;

  always #2 clk = ~clk;

  rasp_top #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .push_i(push_i),
    .pop_i(pop_i), .wr_data_i(wr_data_i), .wr_tag_i(wr_tag_i),
    .ret_addr_o(ret_addr_o), .ret_valid_o(ret_valid_o), .fault_tag_o(fault_tag_o),
    .fault_ovf_o(fault_ovf_o), .fault_unf_o(fault_unf_o), .fault_proto_o(fault_proto_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock of stimulus, model update and full output comparison
  task automatic step(input bit c, input bit r, input bit pu, input bit po,
                      input logic [AW-1:0] d, input logic [1:0] t, input string req);
    bit e_valid = 0, e_tag = 0, e_ovf = 0, e_unf = 0, e_proto;
    @(negedge clk);
    call_i = c; ret_i = r; push_i = pu; pop_i = po; wr_data_i = d; wr_tag_i = t;
    e_proto = (int'(c) + int'(r) + int'(pu) + int'(po)) > 1;
    if (r || po) begin
      if (stk.size() == 0) e_unf = 1;
      else begin e_valid = 1; m_addr = stk.pop_back(); end
    end else if (c) begin
      if (stk.size() == DEPTH) e_ovf = 1; else stk.push_back(d);
    end else if (pu) begin
      if (t != 2'b01) e_tag = 1;
      else if (stk.size() == DEPTH) e_ovf = 1;
      else stk.push_back(d);
    end
    @(posedge clk); #1;
    chk(ret_valid_o == e_valid, req, "ret_valid_o", AW'(ret_valid_o), AW'(e_valid));
    chk(ret_addr_o == m_addr, req, "ret_addr_o", ret_addr_o, m_addr);
    chk(fault_tag_o == e_tag, "R5", "fault_tag_o", AW'(fault_tag_o), AW'(e_tag));
    chk(fault_ovf_o == e_ovf, "R6", "fault_ovf_o", AW'(fault_ovf_o), AW'(e_ovf));
    chk(fault_unf_o == e_unf, "R7", "fault_unf_o", AW'(fault_unf_o), AW'(e_unf));
    chk(fault_proto_o == e_proto, "R8", "fault_proto_o", AW'(fault_proto_o), AW'(e_proto));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; call_i = 0; ret_i = 0; push_i = 0; pop_i = 0;
    repeat (2) @(posedge clk);
    #1;
    stk.delete(); m_addr = '0;
    chk({ret_valid_o, fault_tag_o, fault_ovf_o, fault_unf_o, fault_proto_o} == 5'b0,
        "R1", "flags after reset", AW'({ret_valid_o, fault_tag_o, fault_ovf_o,
        fault_unf_o, fault_proto_o}), '0);
    chk(ret_addr_o == '0, "R1", "ret_addr_o after reset", ret_addr_o, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: an empty stack right after reset underflows
    step(0, 1, 0, 0, '0, 2'b00, "R1");
    // R2: calls store regardless of tag; R3 returns in LIFO order
    step(1, 0, 0, 0, 32'hA000_0010, 2'b10, "R2");
    step(1, 0, 0, 0, 32'hA000_0020, 2'b00, "R2");
    step(0, 1, 0, 0, '0, 2'b00, "R3");
    step(0, 0, 0, 0, '0, 2'b00, "R3");
    // R5: tagged push accepted, other tags rejected; R4 dedicated pop
    step(0, 0, 1, 0, 32'hB000_0001, 2'b01, "R5");
    step(0, 0, 1, 0, 32'hDEAD_0000, 2'b10, "R5");
    step(0, 0, 1, 0, 32'hDEAD_0001, 2'b11, "R5");
    step(0, 0, 1, 0, 32'hDEAD_0002, 2'b00, "R5");
    step(0, 0, 0, 1, '0, 2'b00, "R4");
    step(0, 0, 0, 1, '0, 2'b00, "R4");
    step(0, 0, 0, 1, '0, 2'b00, "R7");
    // R9: fill to DEPTH, then R6 overflow on both insertion kinds
    for (int i = 0; i < DEPTH; i++)
      step(i % 2 == 0, 0, i % 2 == 1, 0, 32'hC000_0000 + i, 2'b01, "R9");
    step(1, 0, 0, 0, 32'hEEEE_0001, 2'b01, "R6");
    step(0, 0, 1, 0, 32'hEEEE_0002, 2'b01, "R6");
    step(0, 0, 1, 0, 32'hEEEE_0003, 2'b10, "R5");
    // R8: simultaneous strobes on a full stack
    step(1, 1, 0, 0, 32'hEEEE_0004, 2'b01, "R8");
    step(1, 0, 1, 0, 32'hC100_0000, 2'b01, "R8");
    step(0, 0, 1, 1, 32'hEEEE_0005, 2'b01, "R8");
    for (int i = 0; i < DEPTH + 1; i++) step(0, i % 2, 0, (i + 1) % 2, '0, 2'b00, "R9");
    // R1: reset mid-run empties the stack
    step(1, 0, 0, 0, 32'hF000_0001, 2'b01, "R2");
    do_reset();
    step(0, 0, 0, 1, '0, 2'b00, "R1");
    // mixed random traffic weighted toward insertion
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 99);
      bit c = (k < 30), pu = (k >= 25 && k < 55), r = (k >= 55 && k < 72);
      bit po = (k >= 70 && k < 85);
      logic [1:0] t = ($urandom_range(0, 9) < 6) ? 2'b01 : 2'($urandom_range(0, 3));
      step(c, r, pu, po, AW'($urandom), t, "R3");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule